// File: doc/BRIEF.md
# Streaming Program Image Loader

This block takes a program file that a host pushes through a device data window, one file byte per bus address, and places it into the memory of a target machine. The byte travels in bits 7:0 of the 16-bit host word. The first two bytes of the file are not stored. They form a little-endian load address. Every later byte goes to the target memory at that load address plus its distance from the header. When the host signals that the stream is finished, the block holds the target in reset for a fixed number of cycles and then requests a start.

The target write port has a ready input. A data write that meets a busy memory stalls the host through the wait output until the memory accepts the byte. A file with no data byte after its header is rejected with an error flag, and the target is left alone.

The control is a five-state machine:
- LD_IDLE: no header is captured.
- LD_HDR: the low address byte is held.
- LD_LOAD: the header is complete and data bytes flow.
- LD_RST: target reset is held.
- LD_GO: the one-cycle start request.

The transitions are:
- IDLE→HDR, HDR→HDR and LOAD→HDR on a write at offset 0.
- HDR→LOAD on a write at offset 1.
- IDLE→IDLE and HDR→IDLE on completion, raising the error.
- LOAD→IDLE on completion with no data byte, raising the error.
- LOAD→RST on completion after at least one data byte.
- RST→GO when the reset timer expires.
- GO→IDLE unconditionally.

Top module: `prog_image_loader`

## Requirements
- R1: Only bits 7:0 of a host write word are used; bits 15:8 are ignored. A read returns 0x00 in bits 15:8. Its low byte is the captured load-address low byte at offset 0, the high byte at offset 1, and 0x00 at any other offset. After reset both captured bytes are 0x00.
- R2: The header is little-endian: the byte written at offset 0 is load-address bits 7:0, and the byte written at offset 1 (after offset 0) is bits 15:8.
- R3: Once the header is complete, a write at offset k ≥ 2 drives mem_we high in the same cycle as the access. mem_addr is (load address + k − 2) modulo 2^16, and mem_data is the written low byte.
- R4: While such a data write is presented and mem_ready is low, wait_o is high. The write completes, with wait_o low, in the first cycle mem_ready is high.
- R5: A write has an effect only when dev_hit, ce and we are all high. dev_hit alone, or we without ce, neither writes target memory nor changes the captured header.
- R6: A fin pulse in LD_LOAD after at least one completed data write raises tgt_reset from the next cycle for exactly 16 cycles. tgt_start is then high for exactly one cycle, after which both are low.
- R7: A fin pulse before any data byte was written (file shorter than 3 bytes) sets err_o from the next cycle and never raises tgt_reset or tgt_start.
- R8: A write at offset 0 restarts header capture from that byte, clears err_o, and discards the data-seen condition.
- R9: While tgt_reset or tgt_start is high, host writes are ignored: mem_we and wait_o stay low.
- R10: A data-offset write before the header is complete does not write target memory and does not stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_hit | input | 1 | Host currently addresses this loader |
| ce | input | 1 | Host access to the data window in progress |
| we | input | 1 | The access is a write |
| addr | input | 28 | Byte offset within the stream |
| wdata | input | 16 | Host write word, file byte in bits 7:0 |
| rdata | output | 16 | Host read word |
| wait_o | output | 1 | Stall the host access |
| fin | input | 1 | One-cycle stream-complete strobe from the status handshake |
| err_o | output | 1 | Last completion was rejected as too short |
| mem_we | output | 1 | Target memory write request |
| mem_addr | output | 16 | Target memory address |
| mem_data | output | 8 | Target memory write byte |
| mem_ready | input | 1 | Target memory accepts the write this cycle |
| tgt_reset | output | 1 | Target machine reset |
| tgt_start | output | 1 | Target start request pulse |

## Verification
The memory write strobe, address, data, wait and read data are combinational from the current access. The bench therefore samples them 1 ns after the falling edge on which it drove the access, before the edge that completes it. Header capture, the error flag and the state change take effect at the rising edge that ends an access or a fin pulse. These are sampled 1 ns after that edge. The reset output is due from the first edge after fin and is checked on each of the 16 following edges. The start pulse is checked on the 17th, and its removal on the 18th.

// File: rtl/lo_pkg.sv
package lo_pkg;
    localparam int TAW = 16;
    localparam int BW  = 8;

    typedef enum logic [2:0] {
        LD_IDLE,
        LD_HDR,
        LD_LOAD,
        LD_RST,
        LD_GO
    } ld_state_t;
endpackage

// File: rtl/lo_hdr.sv
module lo_hdr
    import lo_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cap_lo,
    input  logic           cap_hi,
    input  logic [BW-1:0]  byte_in,
    input  logic [TAW-1:0] offset,
    output logic [TAW-1:0] base,
    output logic [TAW-1:0] tgt_addr
);
    logic [BW-1:0] lo_q;
    logic [BW-1:0] hi_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= byte_in;
            if (cap_hi) hi_q <= byte_in;
        end
    end

    assign base     = {hi_q, lo_q};
    assign tgt_addr = base + offset - TAW'(2);
endmodule

// File: rtl/lo_timer.sv
module lo_timer #(
    parameter int RST_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = $clog2(RST_CYC + 1);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + CW'(1);
    end

    assign expired = run && (cnt == CW'(RST_CYC - 1));
endmodule

// File: rtl/lo_fsm.sv
module lo_fsm
    import lo_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_hdr0,
    input  logic      wr_hdr1,
    input  logic      data_done,
    input  logic      fin,
    input  logic      tmr_expired,
    output logic      hdr_open,
    output logic      hi_open,
    output logic      load_phase,
    output logic      seq_reset,
    output logic      seq_start,
    output logic      err_o
);
    ld_state_t state, nxt;
    logic      seen_q;
    logic      err_q;

    always_comb begin
        nxt = state;
        unique case (state)
            LD_IDLE: if (wr_hdr0) nxt = LD_HDR;
            LD_HDR: begin
                if (wr_hdr0)      nxt = LD_HDR;
                else if (wr_hdr1) nxt = LD_LOAD;
                else if (fin)     nxt = LD_IDLE;
            end
            LD_LOAD: begin
                if (wr_hdr0)  nxt = LD_HDR;
                else if (fin) nxt = seen_q ? LD_RST : LD_IDLE;
            end
            LD_RST:  if (tmr_expired) nxt = LD_GO;
            LD_GO:   nxt = LD_IDLE;
            default: nxt = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= LD_IDLE;
            seen_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            state <= nxt;
            if (wr_hdr0)        seen_q <= 1'b0;
            else if (data_done) seen_q <= 1'b1;
            if (wr_hdr0) err_q <= 1'b0;
            else if (fin && (state == LD_IDLE || state == LD_HDR ||
                             (state == LD_LOAD && !seen_q)))
                err_q <= 1'b1;
        end
    end

    always_comb begin
        hdr_open   = 1'b0;
        hi_open    = 1'b0;
        load_phase = 1'b0;
        seq_reset  = 1'b0;
        seq_start  = 1'b0;
        unique case (state)
            LD_IDLE: hdr_open = 1'b1;
            LD_HDR: begin
                hdr_open = 1'b1;
                hi_open  = 1'b1;
            end
            LD_LOAD: begin
                hdr_open   = 1'b1;
                load_phase = 1'b1;
            end
            LD_RST:  seq_reset = 1'b1;
            LD_GO:   seq_start = 1'b1;
            default: ;
        endcase
        err_o = err_q;
    end
endmodule

// File: rtl/prog_image_loader.sv
module prog_image_loader
    import lo_pkg::*;
#(
    parameter int AW      = 28,
    parameter int DW      = 16,
    parameter int RST_CYC = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dev_hit,
    input  logic           ce,
    input  logic           we,
    input  logic [AW-1:0]  addr,
    input  logic [DW-1:0]  wdata,
    output logic [DW-1:0]  rdata,
    output logic           wait_o,
    input  logic           fin,
    output logic           err_o,
    output logic           mem_we,
    output logic [TAW-1:0] mem_addr,
    output logic [BW-1:0]  mem_data,
    input  logic           mem_ready,
    output logic           tgt_reset,
    output logic           tgt_start
);
    logic           acc_wr, off0, off1, offd;
    logic           hdr_open, hi_open, load_phase;
    logic           wr_hdr0, wr_hdr1, data_done, tmr_expired;
    logic [TAW-1:0] base;
    logic [BW-1:0]  rd_byte;
    logic           unused_hi;

    assign unused_hi = ^wdata[DW-1:BW];

    assign acc_wr = dev_hit && ce && we;
    assign off0   = (addr == AW'(0));
    assign off1   = (addr == AW'(1));
    assign offd   = !off0 && !off1;

    assign wr_hdr0   = acc_wr && off0 && hdr_open;
    assign wr_hdr1   = acc_wr && off1 && hi_open;
    assign mem_we    = acc_wr && offd && load_phase;
    assign wait_o    = mem_we && !mem_ready;
    assign data_done = mem_we && mem_ready;
    assign mem_data  = wdata[BW-1:0];

    lo_hdr u_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_lo   (wr_hdr0),
        .cap_hi   (wr_hdr1),
        .byte_in  (wdata[BW-1:0]),
        .offset   (addr[TAW-1:0]),
        .base     (base),
        .tgt_addr (mem_addr)
    );

    lo_timer #(.RST_CYC(RST_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (tgt_reset),
        .expired (tmr_expired)
    );

    lo_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_hdr0     (wr_hdr0),
        .wr_hdr1     (wr_hdr1),
        .data_done   (data_done),
        .fin         (fin),
        .tmr_expired (tmr_expired),
        .hdr_open    (hdr_open),
        .hi_open     (hi_open),
        .load_phase  (load_phase),
        .seq_reset   (tgt_reset),
        .seq_start   (tgt_start),
        .err_o       (err_o)
    );

    always_comb begin
        if (off0)      rd_byte = base[BW-1:0];
        else if (off1) rd_byte = base[TAW-1:BW];
        else           rd_byte = '0;
    end
    assign rdata = {{(DW-BW){1'b0}}, rd_byte};
endmodule

// File: rtl/lo_chk.sv
module lo_chk #(
    parameter int RST_CYC = 16
) (
    input logic clk,
    input logic rst_n,
    input logic dev_hit,
    input logic ce,
    input logic we,
    input logic fin,
    input logic err_o,
    input logic mem_we,
    input logic wait_o,
    input logic tgt_reset,
    input logic tgt_start
);
    localparam int CW = $clog2(RST_CYC + 1);
    logic [CW-1:0] rcnt;

    always_ff @(posedge clk) begin
        if (!rst_n || tgt_start) rcnt <= '0;
        else if (tgt_reset)      rcnt <= rcnt + CW'(1);
    end

    // R5
    mem_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (dev_hit && ce && we));
    // R6
    start_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_start |-> $past(tgt_reset));
    // R6
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_start |=> !tgt_start);
    // R6
    reset_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_start |-> (rcnt == CW'(RST_CYC)));
    // R6
    reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgt_reset) |-> $past(fin));
    // R7
    err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_o) |-> $past(fin));
    // R9
    seq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_reset || tgt_start) |-> (!mem_we && !wait_o));
endmodule

bind prog_image_loader lo_chk #(.RST_CYC(RST_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_hit   (dev_hit),
    .ce        (ce),
    .we        (we),
    .fin       (fin),
    .err_o     (err_o),
    .mem_we    (mem_we),
    .wait_o    (wait_o),
    .tgt_reset (tgt_reset),
    .tgt_start (tgt_start)
);

// File: tb/prog_image_loader_tb.sv
`timescale 1ns/1ps
module prog_image_loader_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dev_hit = 1'b0, ce = 1'b0, we = 1'b0, fin = 1'b0, mem_ready = 1'b1;
    logic [27:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        wait_o, err_o, mem_we, tgt_reset, tgt_start;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data;

    int vecs = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    prog_image_loader u_dut (
        .clk(clk), .rst_n(rst_n), .dev_hit(dev_hit), .ce(ce), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wait_o(wait_o),
        .fin(fin), .err_o(err_o), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_ready(mem_ready),
        .tgt_reset(tgt_reset), .tgt_start(tgt_start)
    );

    // {new stream, load address, offset, byte}
    localparam logic [40:0] VEC [7] = '{
        {1'b1, 16'h0801, 16'd2, 8'hA9},
        {1'b0, 16'h0801, 16'd3, 8'h00},
        {1'b0, 16'h0801, 16'd4, 8'h8D},
        {1'b1, 16'hFFFE, 16'd2, 8'h11},
        {1'b0, 16'hFFFE, 16'd3, 8'h22},
        {1'b0, 16'hFFFE, 16'd4, 8'h33},
        {1'b0, 16'hFFFE, 16'd5, 8'h44}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vecs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_wr(input logic [27:0] off, input logic [15:0] w);
        @(negedge clk);
        dev_hit = 1'b1; ce = 1'b1; we = 1'b1; addr = off; wdata = w;
        #1;
    endtask

    task automatic end_acc();
        while (wait_o) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        dev_hit = 1'b0; ce = 1'b0; we = 1'b0;
    endtask

    task automatic put(input logic [27:0] off, input logic [15:0] w);
        start_wr(off, w);
        end_acc();
    endtask

    task automatic rd(input logic [27:0] off, output logic [15:0] v);
        @(negedge clk);
        dev_hit = 1'b1; ce = 1'b1; we = 1'b0; addr = off;
        #1 v = rdata;
        end_acc();
    endtask

    task automatic pulse_fin();
        @(negedge clk); fin = 1'b1;
        @(posedge clk); #1 fin = 1'b0;
    endtask

    initial begin
        #(200000 * 8);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] load;
        logic [15:0] ex;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // reset state (R1)
        @(negedge clk); #1;
        chk(rdata == 16'h0000, "R1 reset rdata", rdata, 0);
        chk({mem_we, wait_o, tgt_reset, tgt_start, err_o} == 5'b0, "R1 reset outputs",
            {mem_we, wait_o, tgt_reset, tgt_start, err_o}, 0);

        // R1 / R2: header bytes land little-endian, upper word bits ignored
        put(28'd0, 16'hAB34);
        put(28'd1, 16'hCD12);
        rd(28'd0, v); chk(v == 16'h0034, "R2 low header byte", v, 16'h0034);
        rd(28'd1, v); chk(v == 16'h0012, "R2 high header byte", v, 16'h0012);
        rd(28'd9, v); chk(v == 16'h0000, "R1 other offset read", v, 0);

        // vector table: R3 mapping with 16-bit wrap, R8 restart per stream
        for (int i = 0; i < 7; i++) begin
            load = VEC[i][39:24];
            if (VEC[i][40]) begin
                put(28'd0, {8'hC3, load[7:0]});
                put(28'd1, {8'hC3, load[15:8]});
            end
            ex = load + VEC[i][23:8] - 16'd2;
            start_wr({12'd0, VEC[i][23:8]}, {8'h5A, VEC[i][7:0]});
            chk(mem_we && !wait_o, "R3 write strobe", {mem_we, wait_o}, 2'b10);
            chk(mem_addr == ex, "R3 target address", mem_addr, ex);
            chk(mem_data == VEC[i][7:0], "R3 target byte", mem_data, VEC[i][7:0]);
            end_acc();
        end

        // R4: stall while target memory is busy (offset 6 -> 0x0002)
        mem_ready = 1'b0;
        start_wr(28'd6, 16'h0077);
        chk(wait_o && mem_we, "R4 wait on busy", {wait_o, mem_we}, 2'b11);
        repeat (3) @(negedge clk);
        #1 chk(wait_o && mem_addr == 16'h0002, "R4 held stall", {wait_o, mem_addr}, {1'b1, 16'h0002});
        @(negedge clk); mem_ready = 1'b1; #1;
        chk(!wait_o && mem_we, "R4 release", {wait_o, mem_we}, 2'b01);
        end_acc();

        // R5: gating
        @(negedge clk); dev_hit = 1'b0; ce = 1'b1; we = 1'b1; addr = 28'd2; #1;
        chk(!mem_we, "R5 no write without dev_hit", mem_we, 0);
        dev_hit = 1'b1; ce = 1'b0; #1;
        chk(!mem_we, "R5 no write without ce", mem_we, 0);
        end_acc();
        @(negedge clk); dev_hit = 1'b0; ce = 1'b1; we = 1'b1; addr = 28'd0; wdata = 16'h0055;
        end_acc();
        rd(28'd0, v); chk(v == 16'h00FE, "R5 header untouched", v, 16'h00FE);

        // R6 sequence with R9 writes held throughout
        pulse_fin();
        dev_hit = 1'b1; ce = 1'b1; we = 1'b1; addr = 28'd2; wdata = 16'h0099;
        for (int i = 0; i < 16; i++) begin
            chk(tgt_reset && !tgt_start, "R6 reset window", {tgt_reset, tgt_start}, 2'b10);
            chk(!mem_we && !wait_o, "R9 write ignored", {mem_we, wait_o}, 0);
            @(posedge clk); #1;
        end
        chk(tgt_start && !tgt_reset, "R6 start pulse", {tgt_reset, tgt_start}, 2'b01);
        chk(!mem_we && !wait_o, "R9 write ignored at start", {mem_we, wait_o}, 0);
        dev_hit = 1'b0; ce = 1'b0; we = 1'b0;
        @(posedge clk); #1;
        chk(!tgt_start && !tgt_reset, "R6 sequence end", {tgt_reset, tgt_start}, 0);
        chk(!err_o, "R6 no error", err_o, 0);

        // R7: header only, then completion
        put(28'd0, 16'h0000);
        put(28'd1, 16'h0010);
        pulse_fin();
        chk(err_o, "R7 error set", err_o, 1);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 20; i++) begin
                if (tgt_reset || tgt_start) seen = 1'b1;
                @(posedge clk); #1;
            end
            chk(!seen, "R7 no reset or start", seen, 0);
        end

        // R8: offset 0 restarts and clears error
        put(28'd0, 16'h0042);
        chk(!err_o, "R8 error cleared", err_o, 1'b0);
        rd(28'd0, v); chk(v == 16'h0042, "R8 new low byte", v, 16'h0042);

        // R10: data before header complete
        start_wr(28'd2, 16'h0066);
        chk(!mem_we && !wait_o, "R10 early data ignored", {mem_we, wait_o}, 0);
        end_acc();

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end
endmodule